// File: doc/BRIEF.md
# Tone Transceiver Host Register Port

This block is the host-side register port of a dual-tone signalling transceiver. A small processor reaches it over a 4-bit data bus. The bus has an active-low chip select, separate active-low read and write strobes, and one register-select line. Through this port the processor loads the code to transmit and reads back the last decoded receive code. It also programs two control registers that share one address, and polls a status register whose event flags clear when read.

All bus inputs pass through synchronizers into the system clock domain. An access takes effect when its strobe is released. The read bus is modelled as a data output with an output enable. The block drives the control bits out to the transmitter and receiver. It takes event inputs from them: receive code valid, transmitter ready, delayed steering level and call-progress comparator. It drives an active-low pin whose meaning depends on mode: a flag interrupt, the comparator square wave, or inverted steering.

Top module: `tone_host_regs`

## Requirements
- R1: With chip select low, releasing the write strobe with select 0 loads the transmit code (tx_code_o) and pulses tx_load_o for one cycle. Reading with select 0 returns the last receive code captured on rx_valid_i. Strobes seen while chip select is high change nothing, and no register changes while a strobe is still held low.
- R2: Control A bit positions: b0 tone output enable, b1 mode (0 tone-pair, 1 call-progress), b2 interrupt enable, b3 redirect.
- R3: A control write to A with b3=1 sends only the next control write (select 1) to control B, and leaves A unchanged by that write. Every later control write goes to A again.
- R4: Control B bit positions: b0 burst disable (burst is active when b0=0, so burst_en_o = ~b0), b1 test, b2 single tone (1) or pair (0), b3 column (1) or row (0).
- R5: After reset both control registers are zero: tone-pair mode, burst active, every other control output low, irq_no high, and status flags b0..b2 clear.
- R6: A status read (select 1) returns {b3 steering, b2 receive full, b1 transmit empty, b0 interrupt}. The value returned is the one before the read. Afterwards b0, b1 and b2 are clear unless a new event arrives. b0 sets whenever b1 or b2 sets.
- R7: Transmit empty (b1) sets on tx_ready_i only while burst is active, and is held clear while burst is off.
- R8: An event that lands in the same cycle as the clearing status read is kept, and shows in the next read.
- R9: Status b3 follows dsteer_i and is not cleared by a status read.
- R10: In tone-pair mode with interrupts enabled, irq_no is low while status b0 is set. With interrupts disabled and test off, irq_no stays high.
- R11: In call-progress mode with interrupts enabled, irq_no follows cp_cmp_i. With interrupts disabled, irq_no stays high.
- R12: Test mode in tone-pair mode drives irq_no with the inverse of dsteer_i. In call-progress mode the test bit has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rs_i | input | 1 | Register select (0 data, 1 control/status) |
| data_i | input | 4 | Write data bus |
| data_o | output | 4 | Read data bus |
| data_oe_o | output | 1 | Read bus drive enable |
| irq_no | output | 1 | Interrupt / call-progress / test pin, active low |
| tx_code_o | output | 4 | Code to transmit |
| tx_load_o | output | 1 | One-cycle pulse on transmit write |
| tone_en_o | output | 1 | Tone output enable |
| cp_mode_o | output | 1 | Call-progress mode selected |
| burst_en_o | output | 1 | Burst timing active |
| test_o | output | 1 | Test mode bit |
| single_o | output | 1 | Single-tone generation |
| col_sel_o | output | 1 | Column group selected for single tone |
| rx_valid_i | input | 1 | Receive code valid pulse |
| rx_code_i | input | 4 | Decoded receive code |
| tx_ready_i | input | 1 | Transmitter ready pulse |
| dsteer_i | input | 1 | Delayed steering level |
| cp_cmp_i | input | 1 | Call-progress comparator output |

## Verification
The status register is read in several settings: idle, after a receive event, after a transmitter-ready event with burst on, and with burst off. A receive event is also placed exactly on the cycle the clearing read takes effect. Together these separate pre-clear read-back, clear-on-read and the event-wins priority. Control writes run through the redirect sequence A, B, A. This shows that B is reached only once and that neither register disturbs the other. The pin is observed in each of its modes while the source that mode should ignore is toggled, so that a wrong priority between test, call-progress and flag interrupt shows.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef struct packed {
    logic redirect;
    logic irq_en;
    logic cp_mode;
    logic tone_en;
  } ctl_a_t;

  typedef struct packed {
    logic col_sel;
    logic single;
    logic test;
    logic burst_n;
  } ctl_b_t;

  typedef struct packed {
    logic dsteer;
    logic rx_full;
    logic tx_empty;
    logic irq;
  } stat_t;
endpackage

// File: rtl/thr_sync_pipe.sv
module thr_sync_pipe #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES:0][W-1:0] stg;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o      = stg[STAGES-1];
  assign q_prev_o = stg[STAGES];
endmodule

// File: rtl/thr_ctl_regs.sv
module thr_ctl_regs
  import thr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] data_i,
  output ctl_a_t     ctl_a_o,
  output ctl_b_t     ctl_b_o
);
  ctl_a_t a_q;
  ctl_b_t b_q;
  logic   to_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      to_b_q <= 1'b0;
    end else if (wr_i) begin
      if (to_b_q) begin
        b_q    <= ctl_b_t'(data_i);
        to_b_q <= 1'b0;
      end else begin
        a_q    <= ctl_a_t'(data_i);
        to_b_q <= data_i[3];
      end
    end
  end

  assign ctl_a_o = a_q;
  assign ctl_b_o = b_q;

  assert_redirect_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_b_q && wr_i) |=> !to_b_q) else $error("redirect persisted");
  assert_a_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_b_q && wr_i) |=> $stable(a_q)) else $error("A changed on B write");
  assert_b_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !to_b_q |=> $stable(b_q)) else $error("B changed without redirect");
endmodule

// File: rtl/thr_status.sv
module thr_status
  import thr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rx_valid_i,
  input  logic  tx_ready_i,
  input  logic  burst_on_i,
  input  logic  dsteer_i,
  input  logic  rd_clr_i,
  output stat_t stat_o
);
  logic rx_full_q, tx_empty_q, irq_q, dsteer_q;
  logic tx_evt;

  assign tx_evt = burst_on_i & tx_ready_i;

  // set wins over clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_q  <= 1'b0;
      tx_empty_q <= 1'b0;
      irq_q      <= 1'b0;
      dsteer_q   <= 1'b0;
    end else begin
      rx_full_q  <= rx_valid_i | (rx_full_q & ~rd_clr_i);
      tx_empty_q <= burst_on_i & (tx_ready_i | (tx_empty_q & ~rd_clr_i));
      irq_q      <= rx_valid_i | tx_evt | (irq_q & ~rd_clr_i);
      dsteer_q   <= dsteer_i;
    end
  end

  assign stat_o = '{dsteer: dsteer_q, rx_full: rx_full_q, tx_empty: tx_empty_q, irq: irq_q};

  assert_rx_event_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_full_q) else $error("receive event lost");
  assert_rx_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !rx_valid_i) |=> !rx_full_q) else $error("receive flag not cleared");
  assert_txe_burst_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_on_i |=> !tx_empty_q) else $error("tx empty set with burst off");
endmodule

// File: rtl/thr_irq_mux.sv
module thr_irq_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_en_i,
  input  logic cp_mode_i,
  input  logic test_i,
  input  logic irq_flag_i,
  input  logic dsteer_i,
  input  logic cp_cmp_i,
  output logic irq_no
);
  logic cp_q, pin_d;

  always_comb begin
    if (test_i && !cp_mode_i)    pin_d = ~dsteer_i;
    else if (irq_en_i && cp_mode_i) pin_d = cp_q;
    else if (irq_en_i)           pin_d = ~irq_flag_i;
    else                         pin_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cp_q   <= 1'b0;
      irq_no <= 1'b1;
    end else begin
      cp_q   <= cp_cmp_i;
      irq_no <= pin_d;
    end
  end

  assert_pin_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !(test_i && !cp_mode_i)) |=> irq_no) else $error("pin active while disabled");
endmodule

// File: rtl/tone_host_regs.sv
module tone_host_regs
  import thr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic       rs_i,
  input  logic [3:0] data_i,
  output logic [3:0] data_o,
  output logic       data_oe_o,
  output logic       irq_no,
  output logic [3:0] tx_code_o,
  output logic       tx_load_o,
  output logic       tone_en_o,
  output logic       cp_mode_o,
  output logic       burst_en_o,
  output logic       test_o,
  output logic       single_o,
  output logic       col_sel_o,
  input  logic       rx_valid_i,
  input  logic [3:0] rx_code_i,
  input  logic       tx_ready_i,
  input  logic       dsteer_i,
  input  logic       cp_cmp_i
);
  localparam int unsigned BUS_W = 8;
  localparam logic [BUS_W-1:0] BUS_RST = 8'b1110_0000;

  logic [BUS_W-1:0] bus_cur, bus_prv;
  logic cur_cs_n, cur_rd_n, cur_wr_n, cur_rs;
  logic prv_cs_n, prv_rd_n, prv_wr_n, prv_rs;
  logic [3:0] prv_dat;
  logic rd_acc, wr_acc, tx_wr, ctl_wr, stat_rd;

  ctl_a_t ctl_a;
  ctl_b_t ctl_b;
  stat_t  stat;
  logic [3:0] rx_q, tx_q;
  logic       load_q;

  thr_sync_pipe #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({cs_ni, rd_ni, wr_ni, rs_i, data_i}),
    .q_o      (bus_cur),
    .q_prev_o (bus_prv)
  );

  assign {cur_cs_n, cur_rd_n, cur_wr_n, cur_rs} = bus_cur[7:4];
  assign {prv_cs_n, prv_rd_n, prv_wr_n, prv_rs} = bus_prv[7:4];
  assign prv_dat = bus_prv[3:0];

  // access taken on strobe release, qualified by select seen during the strobe
  assign rd_acc  = cur_rd_n & ~prv_rd_n & ~prv_cs_n;
  assign wr_acc  = cur_wr_n & ~prv_wr_n & ~prv_cs_n;
  assign tx_wr   = wr_acc & ~prv_rs;
  assign ctl_wr  = wr_acc &  prv_rs;
  assign stat_rd = rd_acc &  prv_rs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      load_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      load_q <= tx_wr;
      if (tx_wr)      tx_q <= prv_dat;
      if (rx_valid_i) rx_q <= rx_code_i;
    end
  end

  thr_ctl_regs u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr),
    .data_i  (prv_dat),
    .ctl_a_o (ctl_a),
    .ctl_b_o (ctl_b)
  );

  thr_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .tx_ready_i (tx_ready_i),
    .burst_on_i (~ctl_b.burst_n),
    .dsteer_i   (dsteer_i),
    .rd_clr_i   (stat_rd),
    .stat_o     (stat)
  );

  thr_irq_mux u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_en_i   (ctl_a.irq_en),
    .cp_mode_i  (ctl_a.cp_mode),
    .test_i     (ctl_b.test),
    .irq_flag_i (stat.irq),
    .dsteer_i   (stat.dsteer),
    .cp_cmp_i   (cp_cmp_i),
    .irq_no     (irq_no)
  );

  assign data_oe_o  = ~cur_cs_n & ~cur_rd_n;
  assign data_o     = cur_rs ? stat : rx_q;
  assign tx_code_o  = tx_q;
  assign tx_load_o  = load_q;
  assign tone_en_o  = ctl_a.tone_en;
  assign cp_mode_o  = ctl_a.cp_mode;
  assign burst_en_o = ~ctl_b.burst_n;
  assign test_o     = ctl_b.test;
  assign single_o   = ctl_b.single;
  assign col_sel_o  = ctl_b.col_sel;

  assert_one_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o) else $error("transmit load longer than one cycle");
endmodule

// File: tb/tone_host_regs_tb_top.sv
`timescale 1ns/1ps
module tone_host_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rs = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic oe, irq_n;
  logic [3:0] tx_code;
  logic tx_load, tone_en, cp_mode, burst_en, test_m, single_m, col_sel;
  logic rx_valid = 1'b0;
  logic [3:0] rx_code = '0;
  logic tx_ready = 1'b0, dsteer = 1'b0, cp_cmp = 1'b0;

  int checks = 0;
  int errors = 0;
  int loads = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] last_rd = '0;
  logic       prev_oe = 1'b0;

  always #4 clk = ~clk;

  tone_host_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n), .rs_i(rs),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .irq_no(irq_n),
    .tx_code_o(tx_code), .tx_load_o(tx_load), .tone_en_o(tone_en), .cp_mode_o(cp_mode),
    .burst_en_o(burst_en), .test_o(test_m), .single_o(single_m), .col_sel_o(col_sel),
    .rx_valid_i(rx_valid), .rx_code_i(rx_code), .tx_ready_i(tx_ready),
    .dsteer_i(dsteer), .cp_cmp_i(cp_cmp)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data captured just before the strobe release
  always @(negedge clk) begin
    if (tx_load) loads++;
    if (prev_oe && !oe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: unexpected read got %h exp none", last_rd);
      end else begin
        check(tag_q.pop_front(), last_rd, exp_q.pop_front());
      end
    end
    if (oe) last_rd = dout;
    prev_oe = oe;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic [3:0] d);
    @(negedge clk); cs_n = 1'b0; rs = sel; din = d; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    idle(5);
  endtask

  task automatic bus_read(input logic sel, input logic [3:0] exp, input string tag, input bit race);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); cs_n = 1'b0; rs = sel; rd_n = 1'b0;
    idle(5);
    rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    if (race) begin
      @(negedge clk); rx_code = 4'hC; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
    end
    idle(5);
  endtask

  task automatic pulse_rx(input logic [3:0] code);
    @(negedge clk); rx_code = code; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    idle(3);
  endtask

  task automatic pulse_tx;
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    idle(3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R5 reset state
    check("R5 irq_n", {3'b0, irq_n}, 4'h1);
    check("R5 ctl", {tone_en, cp_mode, test_m, single_m}, 4'h0);
    check("R5 burst/col", {2'b0, burst_en, col_sel}, 4'b0010);
    check("R5 oe", {3'b0, oe}, 4'h0);
    bus_read(1'b1, 4'h0, "R5 status", 1'b0);

    // R1 transmit write, effect only after release
    bus_write(1'b0, 4'h9);
    check("R1 tx code", tx_code, 4'h9);
    check("R1 load pulses", loads[3:0], 4'h1);
    @(negedge clk); cs_n = 1'b0; rs = 1'b0; din = 4'h3; wr_n = 1'b0;
    idle(5);
    check("R1 no update while strobe low", tx_code, 4'h9);
    wr_n = 1'b1; @(negedge clk); cs_n = 1'b1; idle(5);
    check("R1 tx code second", tx_code, 4'h3);
    @(negedge clk); cs_n = 1'b1; rs = 1'b0; din = 4'h5; wr_n = 1'b0;
    idle(4); wr_n = 1'b1; idle(5);
    check("R1 deselected write ignored", tx_code, 4'h3);
    check("R1 load count", loads[3:0], 4'h2);

    // R2 control A: tone enable + interrupt enable
    bus_write(1'b1, 4'b0101);
    check("R2 tone_en", {3'b0, tone_en}, 4'h1);
    check("R2 cp_mode", {3'b0, cp_mode}, 4'h0);
    pulse_rx(4'h7);
    check("R10 irq asserted on rx full", {3'b0, irq_n}, 4'h0);
    bus_read(1'b1, 4'b0101, "R6 status after rx", 1'b0);
    idle(3);
    check("R10 irq released after read", {3'b0, irq_n}, 4'h1);
    bus_read(1'b0, 4'h7, "R1 rx register", 1'b0);
    bus_read(1'b1, 4'b0000, "R6 cleared", 1'b0);

    // R3 redirect: A(sel) -> B -> A
    bus_write(1'b1, 4'b1101);
    bus_write(1'b1, 4'b0001);
    check("R3 B written: burst off", {3'b0, burst_en}, 4'h0);
    check("R3 A kept on B write", {3'b0, tone_en}, 4'h1);
    bus_write(1'b1, 4'b0001);
    check("R3 B untouched by return write", {3'b0, burst_en}, 4'h0);
    pulse_rx(4'h2);
    check("R10 irq idle when disabled", {3'b0, irq_n}, 4'h1);
    bus_read(1'b1, 4'b0101, "R6 status with irq disabled", 1'b0);

    // R7 burst off: ready ignored
    pulse_tx();
    bus_read(1'b1, 4'b0000, "R7 tx empty held clear", 1'b0);
    bus_write(1'b1, 4'b1100);
    bus_write(1'b1, 4'b0000);
    check("R4 burst active when b0=0", {3'b0, burst_en}, 4'h1);
    check("R2 tone disabled", {3'b0, tone_en}, 4'h0);
    pulse_tx();
    check("R10 irq on tx ready", {3'b0, irq_n}, 4'h0);
    bus_read(1'b1, 4'b0011, "R7 tx empty in burst", 1'b0);
    pulse_tx();
    bus_write(1'b1, 4'b1100);
    bus_write(1'b1, 4'b0001);
    bus_read(1'b1, 4'b0001, "R7 tx empty dropped when burst off", 1'b0);

    // R8 event on the clearing read cycle
    bus_read(1'b1, 4'b0000, "R8 pre-race read", 1'b1);
    bus_read(1'b1, 4'b0101, "R8 event kept", 1'b0);
    bus_read(1'b0, 4'hC, "R8 rx code kept", 1'b0);

    // R9 steering follows level
    dsteer = 1'b1; idle(3);
    bus_read(1'b1, 4'b1000, "R9 steering set", 1'b0);
    bus_read(1'b1, 4'b1000, "R9 steering not cleared", 1'b0);

    // R4 control B fields and R12 test pin
    bus_write(1'b1, 4'b1000);
    bus_write(1'b1, 4'b1110);
    check("R4 B fields", {col_sel, single_m, test_m, burst_en}, 4'b1111);
    check("R12 test pin with steering high", {3'b0, irq_n}, 4'h0);
    dsteer = 1'b0; idle(4);
    check("R12 test pin with steering low", {3'b0, irq_n}, 4'h1);

    // R11 call-progress pass-through, test ignored
    bus_write(1'b1, 4'b0110);
    check("R2 cp mode", {3'b0, cp_mode}, 4'h1);
    cp_cmp = 1'b1; dsteer = 1'b1; idle(4);
    check("R11 cp high / R12 test ignored", {3'b0, irq_n}, 4'h1);
    cp_cmp = 1'b0; idle(4);
    check("R11 cp low", {3'b0, irq_n}, 4'h0);
    cp_cmp = 1'b1; idle(4);
    check("R11 cp high again", {3'b0, irq_n}, 4'h1);
    bus_write(1'b1, 4'b0010);
    cp_cmp = 1'b0; idle(4);
    check("R11 cp without irq enable", {3'b0, irq_n}, 4'h1);

    idle(5);
    check("R6 all reads consumed", exp_q.size() == 0 ? 4'h0 : 4'h1, 4'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule